// File: doc/BRIEF.md
# PS/2 Host Receive Channel with Clock Inhibit

This block is the host end of a PS/2 link, seen from a small microcontroller through a few strobes and flags. It has two modes. When it is enabled for receive, it lets go of the open-drain clock and data lines. It then collects an 11-bit frame from the device, sampling one bit on each falling clock edge. The frame is a zero start bit, eight data bits with the least significant bit first, an odd parity bit and a one stop bit.

When a frame completes, the received byte is flagged ready and an interrupt request is raised. The block also pulls the clock line low. This keeps the device from sending more traffic until software reads the byte. When the channel is disabled, two control bits drive the lines directly, so software can bit-bang the port.

Both line inputs pass through a two-flop synchronizer and a glitch filter that runs on the system clock. Falling edges are detected only after that filtering. A bad start, parity or stop bit sets a sticky frame-error flag. The frame still completes, so the inhibit sequence does not change. A frame that stalls mid-way is abandoned after a programmable number of idle system clocks, and a sticky timeout flag is set.

Top module: `ps2_rx_channel`

## Requirements
- R1: A line level shorter than FILT_LEN system clocks, measured after the two-flop synchronizer, is filtered out. A clock glitch of 2 system clocks inside a high phase neither adds a bit nor corrupts the frame.
- R2: With en_i=1 and rx_mode_i=1 and no byte pending, ps2_clk_oe_o=0 and ps2_data_oe_o=0 (both lines released). An output of 1 means the line is pulled low.
- R3: In receive mode, DATA is sampled on each filtered falling CLK edge. Edge 1 is the start bit, edges 2 to 9 are data bits 0 to 7 (least significant first), edge 10 is parity and edge 11 is stop. The byte appears on rx_data_o. Any device CLK period from 60 to 302 µs is accepted.
- R4: rx_rdy_o and irq_o are set no later than 16 system clocks after the 11th falling CLK edge at the pins, with FILT_LEN=4. This is well inside 1.6 µs at 100 MHz.
- R5: While rx_rdy_o=1 in receive mode, ps2_clk_oe_o=1 (CLK held low), even after the device releases CLK.
- R6: A one-cycle rd_data_i pulse clears rx_rdy_o on the next clock edge and releases CLK at the same moment. rx_data_o keeps the byte.
- R7: irq_o stays at 1 until an irq_src_rd_i pulse, which clears it on the next clock edge. Reading the byte does not clear it.
- R8: With en_i=0, ps2_clk_oe_o equals the inverse of wr_clk_i and ps2_data_oe_o equals the inverse of wr_data_i (a 0 drives low, a 1 releases). Line activity is not received.
- R9: A start bit of 1, even parity, or a stop bit of 0 sets frame_err_o. The byte is still delivered with rx_rdy_o and CLK inhibit. frame_err_o stays at 1 until en_i=0.
- R10: If no falling CLK edge arrives for TIMEOUT_CYC system clocks in mid-frame, the bit position returns to the start and timeout_err_o is set. The next full frame is then received correctly. timeout_err_o stays at 1 until en_i=0.
- R11: With en_i=1 and rx_mode_i=0, both lines are released and no frame is received.
- R12: When a frame completes in the same cycle as rd_data_i or irq_src_rd_i, the completion wins: rx_rdy_o and irq_o are 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| rx_mode_i | input | 1 | 1 selects receive direction |
| wr_clk_i | input | 1 | Bit-bang CLK value when disabled (0 = drive low) |
| wr_data_i | input | 1 | Bit-bang DATA value when disabled (0 = drive low) |
| ps2_clk_i | input | 1 | CLK line level |
| ps2_data_i | input | 1 | DATA line level |
| ps2_clk_oe_o | output | 1 | 1 pulls CLK low |
| ps2_data_oe_o | output | 1 | 1 pulls DATA low |
| rd_data_i | input | 1 | Receive register read strobe |
| irq_src_rd_i | input | 1 | Interrupt source register read strobe |
| rx_data_o | output | 8 | Last received byte |
| rx_rdy_o | output | 1 | Byte ready |
| irq_o | output | 1 | Pending interrupt request |
| frame_err_o | output | 1 | Sticky frame error |
| timeout_err_o | output | 1 | Sticky mid-frame timeout |

## Verification
Frame completion can land in the same clock cycle as a software read strobe, whether of the receive register or of the interrupt source. The bench counts the registers from the 11th falling edge at the pin to the completion pulse. It then raises both read strobes for exactly the cycle in which the ready flag and the interrupt are being set. Afterwards it expects both rx_rdy_o and irq_o to be 1, and it expects a later ordinary read to clear each of them.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int unsigned FRAME_BITS = 11;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned BCNT_W     = $clog2(FRAME_BITS);
  localparam int unsigned NUM_LINES  = 2;
  localparam int unsigned LINE_CLK   = 0;
  localparam int unsigned LINE_DAT   = 1;

  typedef struct packed {
    logic [DATA_BITS-1:0] data;
    logic                 err;
  } ps2_frame_t;
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      lvl_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        lvl_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = lvl_q;

  // R1: filtered level only moves to a synchronized value
  a_r1_follow_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> lvl_q == $past(sync_q[1]));
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 200000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       clk_lvl_i,
  input  logic       dat_lvl_i,
  output logic       done_o,
  output ps2_frame_t frame_o,
  output logic       tmo_o
);
  localparam int unsigned IW = $clog2(TIMEOUT_CYC + 1);

  logic                 prev_q;
  logic [BCNT_W-1:0]    bit_cnt_q;
  logic [DATA_BITS-1:0] sh_q;
  logic                 start_q, par_q;
  logic [IW-1:0]        idle_q;
  logic                 done_q, tmo_q;
  ps2_frame_t           frame_q;
  logic                 fall;

  assign fall = prev_q & ~clk_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= 1'b1;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      start_q   <= 1'b0;
      par_q     <= 1'b0;
      idle_q    <= '0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      frame_q   <= '0;
    end else begin
      prev_q <= clk_lvl_i;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      if (!active_i) begin
        bit_cnt_q <= '0;
        idle_q    <= '0;
      end else if (fall) begin
        idle_q <= '0;
        if (bit_cnt_q == '0) begin
          start_q   <= dat_lvl_i;
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (bit_cnt_q <= BCNT_W'(DATA_BITS)) begin
          sh_q      <= {dat_lvl_i, sh_q[DATA_BITS-1:1]};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (bit_cnt_q == BCNT_W'(DATA_BITS + 1)) begin
          par_q     <= dat_lvl_i;
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else begin
          // stop bit: deliver even on error so the inhibit sequence is unchanged
          done_q       <= 1'b1;
          frame_q.data <= sh_q;
          frame_q.err  <= start_q | ~(^{sh_q, par_q}) | ~dat_lvl_i;
          bit_cnt_q    <= '0;
        end
      end else if (bit_cnt_q == '0) begin
        idle_q <= '0;
      end else if (idle_q == IW'(TIMEOUT_CYC - 1)) begin
        idle_q    <= '0;
        bit_cnt_q <= '0;
        tmo_q     <= 1'b1;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign done_o  = done_q;
  assign frame_o = frame_q;
  assign tmo_o   = tmo_q;

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= BCNT_W'(FRAME_BITS - 1));
  a_r10_tmo_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |-> bit_cnt_q == '0);
  a_r3_no_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !done_q);
endmodule

// File: rtl/ps2_rx_channel.sv
module ps2_rx_channel
  import ps2_rx_pkg::*;
#(
  parameter int unsigned FILT_LEN    = 4,
  parameter int unsigned TIMEOUT_CYC = 200000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rx_mode_i,
  input  logic       wr_clk_i,
  input  logic       wr_data_i,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic       ps2_clk_oe_o,
  output logic       ps2_data_oe_o,
  input  logic       rd_data_i,
  input  logic       irq_src_rd_i,
  output logic [7:0] rx_data_o,
  output logic       rx_rdy_o,
  output logic       irq_o,
  output logic       frame_err_o,
  output logic       timeout_err_o
);
  logic [NUM_LINES-1:0] line_in, line_lvl;
  logic                 active, done, tmo;
  ps2_frame_t           frame;
  logic                 rdy_q, irq_q, ferr_q, terr_q;

  assign line_in[LINE_CLK] = ps2_clk_i;
  assign line_in[LINE_DAT] = ps2_data_i;
  assign active = en_i & rx_mode_i;

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_filt
    ps2_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_in[gi]),
      .level_o(line_lvl[gi])
    );
  end

  ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .clk_lvl_i(line_lvl[LINE_CLK]),
    .dat_lvl_i(line_lvl[LINE_DAT]),
    .done_o   (done),
    .frame_o  (frame),
    .tmo_o    (tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      irq_q  <= 1'b0;
      ferr_q <= 1'b0;
      terr_q <= 1'b0;
    end else begin
      // completion has priority over a same-cycle read
      if (done)           rdy_q <= 1'b1;
      else if (rd_data_i) rdy_q <= 1'b0;
      if (done)              irq_q <= 1'b1;
      else if (irq_src_rd_i) irq_q <= 1'b0;
      if (!en_i) begin
        ferr_q <= 1'b0;
        terr_q <= 1'b0;
      end else begin
        if (done && frame.err) ferr_q <= 1'b1;
        if (tmo)               terr_q <= 1'b1;
      end
    end
  end

  // open-drain: oe=1 pulls the line low
  always_comb begin
    if (!en_i) begin
      ps2_clk_oe_o  = ~wr_clk_i;
      ps2_data_oe_o = ~wr_data_i;
    end else begin
      ps2_clk_oe_o  = rx_mode_i & rdy_q;
      ps2_data_oe_o = 1'b0;
    end
  end

  assign rx_data_o     = frame.data;
  assign rx_rdy_o      = rdy_q;
  assign irq_o         = irq_q;
  assign frame_err_o   = ferr_q;
  assign timeout_err_o = terr_q;

  a_r4_done_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rx_rdy_o && irq_o);
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i && !done |=> !rx_rdy_o);
  a_r7_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_src_rd_i |=> irq_o);
  a_r2_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !rx_rdy_o |-> !ps2_clk_oe_o && !ps2_data_oe_o);
  a_r5_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && active |=> ps2_clk_oe_o);
  a_r9_ferr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o && en_i |=> frame_err_o);
endmodule

// File: tb/sim_ps2_rx_channel.sv
`timescale 1ns/1ps
module sim_ps2_rx_channel;
  localparam int FILT = 4;
  localparam int TMO  = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, rx_mode = 1'b1, wr_clk = 1'b1, wr_data = 1'b1;
  logic dev_clk = 1'b1, dev_data = 1'b1;
  logic rd = 1'b0, irq_rd = 1'b0;
  logic clk_oe, data_oe, rdy, irq, ferr, terr;
  logic [7:0] rdata;
  logic line_clk, line_data;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign line_clk  = dev_clk & ~clk_oe;
  assign line_data = dev_data & ~data_oe;

  ps2_rx_channel #(.FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rx_mode_i(rx_mode),
    .wr_clk_i(wr_clk), .wr_data_i(wr_data),
    .ps2_clk_i(line_clk), .ps2_data_i(line_data),
    .ps2_clk_oe_o(clk_oe), .ps2_data_oe_o(data_oe),
    .rd_data_i(rd), .irq_src_rd_i(irq_rd),
    .rx_data_o(rdata), .rx_rdy_o(rdy), .irq_o(irq),
    .frame_err_o(ferr), .timeout_err_o(terr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [10:0] mk_frame(input logic [7:0] b, input bit bad_s,
                                           input bit bad_p, input bit bad_e);
    return {~bad_e, (~^b) ^ bad_p, b, bad_s};
  endfunction

  // device drives n bits; after the 11th fall CLK is left low
  task automatic send_bits(input logic [10:0] f, input int n, input int half, input int glitch_at);
    for (int i = 0; i < n; i++) begin
      dev_data = f[i];
      cyc(half / 2);
      if (i == glitch_at) begin
        dev_clk = 1'b0; cyc(2); dev_clk = 1'b1;
      end
      cyc(half - half / 2);
      dev_clk = 1'b0;
      if (i < 10) begin
        cyc(half);
        dev_clk = 1'b1;
      end
    end
  endtask

  task automatic rd_pulse();
    rd = 1'b1; cyc(1); rd = 1'b0;
  endtask

  task automatic irq_pulse();
    irq_rd = 1'b1; cyc(1); irq_rd = 1'b0;
  endtask

  task automatic recv_check(input logic [7:0] b, input int half, input int glitch_at, input string tag);
    send_bits(mk_frame(b, 0, 0, 0), 11, half, glitch_at);
    cyc(16);
    chk({tag, " R4 rdy"}, rdy, 1);
    chk({tag, " R4 irq"}, irq, 1);
    chk({tag, " R3 data"}, rdata, b);
    cyc(half);
    dev_clk = 1'b1; dev_data = 1'b1;
    cyc(3);
    chk({tag, " R5 clk held"}, {clk_oe, line_clk}, 2'b10);
    rd_pulse();
    chk({tag, " R6 rdy clr"}, rdy, 0);
    chk({tag, " R6 clk rel"}, clk_oe, 0);
    chk({tag, " R6 data kept"}, rdata, b);
    chk({tag, " R7 irq kept"}, irq, 1);
    irq_pulse();
    chk({tag, " R7 irq clr"}, irq, 0);
    cyc(10);
  endtask

  task automatic t_reset();
    chk("R2 reset flags", {rdy, irq, ferr, terr}, 0);
    chk("R2 released", {clk_oe, data_oe}, 0);
  endtask

  task automatic t_periods();
    recv_check(8'hA5, 30, -1, "R3 p60");
    recv_check(8'h3C, 151, -1, "R3 p302");
    recv_check(8'h01, 70, -1, "R3 lsb");
  endtask

  task automatic t_glitch();
    recv_check(8'h96, 60, 3, "R1 glitch");
  endtask

  task automatic t_frame_err();
    send_bits(mk_frame(8'h5A, 0, 1, 0), 11, 40, -1);
    cyc(16);
    chk("R9 par err", ferr, 1);
    chk("R9 rdy", rdy, 1);
    chk("R9 data", rdata, 8'h5A);
    cyc(40); dev_clk = 1'b1; dev_data = 1'b1; cyc(3);
    chk("R9 inhibit", clk_oe, 1);
    rd_pulse(); irq_pulse();
    recv_check(8'h11, 40, -1, "R9 good");
    chk("R9 sticky", ferr, 1);
    en = 1'b0; cyc(2); en = 1'b1; cyc(2);
    chk("R9 clear", ferr, 0);
    send_bits(mk_frame(8'h22, 1, 0, 0), 11, 40, -1);
    cyc(16);
    chk("R9 start err", ferr, 1);
    cyc(40); dev_clk = 1'b1; dev_data = 1'b1;
    rd_pulse(); irq_pulse();
    en = 1'b0; cyc(2); en = 1'b1; cyc(2);
    send_bits(mk_frame(8'h33, 0, 0, 1), 11, 40, -1);
    cyc(16);
    chk("R9 stop err", ferr, 1);
    cyc(40); dev_clk = 1'b1; dev_data = 1'b1;
    rd_pulse(); irq_pulse();
    en = 1'b0; cyc(2); en = 1'b1; cyc(10);
  endtask

  task automatic t_timeout();
    send_bits(mk_frame(8'hFF, 0, 0, 0), 4, 50, -1);
    dev_data = 1'b1;
    cyc(TMO + 100);
    chk("R10 tmo flag", terr, 1);
    chk("R10 no rdy", rdy, 0);
    recv_check(8'hC3, 50, -1, "R10 resync");
    chk("R10 sticky", terr, 1);
    en = 1'b0; cyc(2); en = 1'b1; cyc(2);
    chk("R10 clear", terr, 0);
  endtask

  task automatic t_bitbang();
    en = 1'b0; wr_clk = 1'b0; wr_data = 1'b1; cyc(1);
    chk("R8 clk low", {clk_oe, data_oe}, 2'b10);
    wr_clk = 1'b1; wr_data = 1'b0; cyc(1);
    chk("R8 data low", {clk_oe, data_oe}, 2'b01);
    wr_data = 1'b1; cyc(1);
    send_bits(mk_frame(8'h77, 0, 0, 0), 11, 40, -1);
    cyc(16);
    chk("R8 no rx", {rdy, irq}, 0);
    cyc(40); dev_clk = 1'b1; dev_data = 1'b1;
    en = 1'b1; rx_mode = 1'b0; cyc(2);
    chk("R11 released", {clk_oe, data_oe}, 0);
    send_bits(mk_frame(8'h44, 0, 0, 0), 11, 40, -1);
    cyc(16);
    chk("R11 no rx", {rdy, irq}, 0);
    cyc(40); dev_clk = 1'b1; dev_data = 1'b1;
    rx_mode = 1'b1; cyc(10);
    chk("R2 enabled rel", {clk_oe, data_oe}, 0);
  endtask

  // completion pulse lands 7 edges after the pin fall; strobes hit the 8th
  task automatic t_same_cycle();
    logic [10:0] f;
    f = mk_frame(8'h6E, 0, 0, 0);
    send_bits(f, 10, 40, -1);
    dev_data = f[10];
    cyc(40);
    dev_clk = 1'b0;
    repeat (7) @(posedge clk);
    #1; rd = 1'b1; irq_rd = 1'b1;
    @(posedge clk);
    #1; rd = 1'b0; irq_rd = 1'b0;
    chk("R12 rdy wins", rdy, 1);
    chk("R12 irq wins", irq, 1);
    chk("R12 data", rdata, 8'h6E);
    cyc(40); dev_clk = 1'b1; dev_data = 1'b1;
    rd_pulse();
    chk("R12 later rd", rdy, 0);
    irq_pulse();
    chk("R12 later irq rd", irq, 0);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_periods();
    t_glitch();
    t_same_cycle();
    t_frame_err();
    t_timeout();
    t_bitbang();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule